// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns one IEEE 754 floating-point operand, either binary64 or binary32, into a signed or unsigned integer of 64 or 32 bits. The operation is chosen for each operand by four inputs: the source precision, the destination width, the signedness, and a 3-bit rounding code. The rounding code travels with the operation; there is no global rounding control. The result comes out with two flags. Invalid reports a NaN or an out-of-range value. Inexact reports that a fraction was discarded.

The converter is a one-stage pipeline. The operand and its controls are taken at a rising clock edge, and the result and flags are held in registers until the next edge. Out-of-range values clamp to the nearest value the destination can hold. NaN gives zero. A 32-bit result sits in the low half of the 64-bit output, and the high half reads as zero.

Top module: `f2i_convert`

## Requirements
- R1: Rounding code 0 rounds to the nearest integer and breaks a tie toward the even integer (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R2: Rounding code 1 rounds toward positive infinity, and code 2 rounds toward negative infinity (1.25 gives 2 or 1; -1.5 gives -1 or -2).
- R3: Rounding code 3 truncates toward zero, and the unused codes 5, 6 and 7 behave exactly like code 3.
- R4: Rounding code 4 rounds to the nearest integer and breaks a tie away from zero (2.5 gives 3, -2.5 gives -3, 0.5 gives 1).
- R5: With `op_dbl`=1 all 64 bits of `op_bits` are read as binary64. With `op_dbl`=0 only `op_bits[31:0]` is read, as binary32, and `op_bits[63:32]` has no effect on the outputs.
- R6: A signed destination clamps a rounded value above 2^(W-1)-1 to 2^(W-1)-1, and one below -2^(W-1) to -2^(W-1), and raises invalid. W is 64 when `dst_wide`=1 and 32 when it is 0. Exactly -2^(W-1) converts with no flag.
- R7: An unsigned destination clamps a positive value above 2^W-1 to 2^W-1 with invalid. A negative input that rounds to zero gives 0 without invalid. Any other negative input gives 0 with invalid.
- R8: A NaN input (exponent all ones, fraction nonzero) gives result 0 with invalid and without inexact. An infinity clamps like any other out-of-range value.
- R9: Inexact is 1 exactly when a finite, in-range input had a nonzero fraction. Invalid and inexact are never both 1.
- R10: With `dst_wide`=0, `result[63:32]` is zero and `result[31:0]` holds the 32-bit two's-complement or unsigned value.
- R11: The outputs show the conversion of the inputs present at the previous rising edge of `clk`. An active-low `rst_n` clears all outputs to zero at once, with no wait for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_bits | input | 64 | Floating-point operand (binary32 in bits 31:0) |
| op_dbl | input | 1 | 1 = binary64 source, 0 = binary32 source |
| dst_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit destination |
| dst_signed | input | 1 | 1 = signed destination, 0 = unsigned |
| rnd_mode | input | 3 | Rounding code (0 near-even, 1 up, 2 down, 3 zero, 4 near-away) |
| result | output | 64 | Integer result |
| invalid | output | 1 | NaN or out-of-range input |
| inexact | output | 1 | Fraction discarded on an in-range input |

## Verification
The block keeps no state between operations, so any internal fault shows up in the very next cycle's result or flags. A bad exponent decode or shift moves the integer by a power of two. A wrong rounding increment shows up only on halfway cases and on cases with a fraction, at the boundary between neighbouring integers. A wrong limit shows up only right at ±2^31, ±2^63 and 2^64. The stimulus therefore puts ties, values just above and below each clamp edge, subnormals, NaN and infinity in both precisions against every rounding code. Any single wrong value or flag stands out on the cycle after its operand.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

   // Per-operation rounding codes; 5..7 are treated as toward zero
   typedef enum logic [2:0] {
      RND_NEAR_EVEN = 3'd0,
      RND_UP        = 3'd1,
      RND_DOWN      = 3'd2,
      RND_ZERO      = 3'd3,
      RND_NEAR_AWAY = 3'd4
   } rnd_e;

   // Decide whether the truncated magnitude must be bumped by one
   function automatic logic rnd_inc(input logic [2:0] code, input logic neg,
                                    input logic lsb, input logic rbit,
                                    input logic stk);
      logic bump;
      case (code)
         RND_NEAR_EVEN: bump = rbit & (stk | lsb);
         RND_UP:        bump = ~neg & (rbit | stk);
         RND_DOWN:      bump = neg & (rbit | stk);
         RND_NEAR_AWAY: bump = rbit;
         default:       bump = 1'b0;
      endcase
      return bump;
   endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int SIG_W  = 53,
   parameter int XE_W   = 13
) (
   input  logic [EXP_W+FRAC_W:0]    fp_bits,
   output logic                     sign,
   output logic                     is_nan,
   output logic                     is_inf,
   output logic signed [XE_W-1:0]   exp_unb,
   output logic [SIG_W-1:0]         sig
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int PAD  = SIG_W - 1 - FRAC_W;

   if (PAD < 0) begin : g_bad_pad
      $error("f2i_unpack: significand field wider than common significand");
   end

   logic [EXP_W-1:0]  e_raw;
   logic [FRAC_W-1:0] frac;
   logic              e_all1;
   logic              e_all0;

   assign sign   = fp_bits[EXP_W+FRAC_W];
   assign e_raw  = fp_bits[FRAC_W +: EXP_W];
   assign frac   = fp_bits[FRAC_W-1:0];
   assign e_all1 = &e_raw;
   assign e_all0 = ~|e_raw;
   assign is_nan = e_all1 & (|frac);
   assign is_inf = e_all1 & ~(|frac);

   // Subnormals share the exponent of the smallest normal, hidden bit 0
   assign exp_unb = $signed(e_all0 ? XE_W'(1) : XE_W'(e_raw)) - $signed(XE_W'(BIAS));
   assign sig     = SIG_W'({~e_all0, frac}) << PAD;

endmodule

// File: rtl/f2i_shift_round.sv
module f2i_shift_round
   import f2i_pkg::*;
#(
   parameter int SIG_W = 53,
   parameter int INT_W = 64,
   parameter int XE_W  = 13
) (
   input  logic                   sign,
   input  logic signed [XE_W-1:0] exp_unb,
   input  logic [SIG_W-1:0]       sig,
   input  logic [2:0]             mode,
   output logic [INT_W:0]         mag,
   output logic                   huge,
   output logic                   frac_nz
);
   localparam int FPOS = SIG_W - 1;
   localparam int TW   = SIG_W + INT_W;

   logic [TW-1:0]    t;
   logic [INT_W-1:0] ipart;
   logic             rbit;
   logic             stk;
   int               e;
   int               sh;

   always_comb begin
      e     = int'(exp_unb);
      huge  = 1'b0;
      ipart = '0;
      rbit  = 1'b0;
      stk   = 1'b0;
      t     = '0;
      sh    = 0;
      if (e >= INT_W) begin
         huge = 1'b1;
      end else if (e >= FPOS) begin
         ipart = INT_W'(sig) << (e - FPOS);
      end else begin
         sh = FPOS - e;
         if (sh > INT_W) sh = INT_W;
         t     = {sig, {INT_W{1'b0}}} >> sh;
         ipart = INT_W'(t[TW-1:INT_W]);
         rbit  = t[INT_W-1];
         stk   = |t[INT_W-2:0];
      end
   end

   assign frac_nz = rbit | stk;
   assign mag     = {1'b0, ipart} + (INT_W+1)'(rnd_inc(mode, sign, ipart[0], rbit, stk));

endmodule

// File: rtl/f2i_saturate.sv
module f2i_saturate #(
   parameter int INT_W    = 64,
   parameter int NARROW_W = 32
) (
   input  logic [INT_W:0]   mag,
   input  logic             huge,
   input  logic             frac_nz,
   input  logic             sign,
   input  logic             is_nan,
   input  logic             dst_wide,
   input  logic             dst_signed,
   output logic [INT_W-1:0] value,
   output logic             invalid,
   output logic             inexact
);
   localparam int MW = INT_W + 1;

   logic [MW-1:0]    u_max;
   logic [MW-1:0]    s_max;
   logic [MW-1:0]    s_negmax;
   logic [MW-1:0]    pos_lim;
   logic [INT_W-1:0] mask;

   assign u_max    = dst_wide ? {1'b0, {INT_W{1'b1}}} : MW'({NARROW_W{1'b1}});
   assign s_max    = u_max >> 1;
   assign s_negmax = s_max + MW'(1);
   assign pos_lim  = dst_signed ? s_max : u_max;
   assign mask     = u_max[INT_W-1:0];

   always_comb begin
      value   = '0;
      invalid = 1'b0;
      inexact = 1'b0;
      if (is_nan) begin
         invalid = 1'b1;
      end else if (!sign) begin
         if (huge || mag > pos_lim) begin
            value   = pos_lim[INT_W-1:0];
            invalid = 1'b1;
         end else begin
            value   = mag[INT_W-1:0];
            inexact = frac_nz;
         end
      end else if (dst_signed) begin
         if (huge || mag > s_negmax) begin
            value   = (-s_negmax[INT_W-1:0]) & mask;
            invalid = 1'b1;
         end else begin
            value   = (-mag[INT_W-1:0]) & mask;
            inexact = frac_nz;
         end
      end else if (!huge && mag == '0) begin
         inexact = frac_nz;
      end else begin
         invalid = 1'b1;
      end
   end

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert #(
   parameter int D_EXP    = 11,
   parameter int D_FRAC   = 52,
   parameter int S_EXP    = 8,
   parameter int S_FRAC   = 23,
   parameter int INT_W    = 64,
   parameter int NARROW_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [63:0]      op_bits,
   input  logic             op_dbl,
   input  logic             dst_wide,
   input  logic             dst_signed,
   input  logic [2:0]       rnd_mode,
   output logic [63:0]      result,
   output logic             invalid,
   output logic             inexact
);
   localparam int SIG_W = D_FRAC + 1;
   localparam int XE_W  = D_EXP + 2;
   localparam int NFMT  = 2;

   if (INT_W != 64 || NARROW_W >= INT_W || S_FRAC > D_FRAC || S_EXP > D_EXP
       || INT_W < SIG_W || D_EXP + D_FRAC + 1 > 64) begin : g_bad_cfg
      $error("f2i_convert: unsupported format or width parameters");
   end

   logic                   sign_v [NFMT];
   logic                   nan_v  [NFMT];
   logic                   inf_v  [NFMT];
   logic signed [XE_W-1:0] exp_v  [NFMT];
   logic [SIG_W-1:0]       sig_v  [NFMT];

   // Index 0 decodes binary64, index 1 decodes binary32
   for (genvar g = 0; g < NFMT; g++) begin : g_fmt
      localparam int EW = (g == 0) ? D_EXP  : S_EXP;
      localparam int FW = (g == 0) ? D_FRAC : S_FRAC;
      f2i_unpack #(.EXP_W(EW), .FRAC_W(FW), .SIG_W(SIG_W), .XE_W(XE_W)) u_unpack (
         .fp_bits (op_bits[EW+FW:0]),
         .sign    (sign_v[g]),
         .is_nan  (nan_v[g]),
         .is_inf  (inf_v[g]),
         .exp_unb (exp_v[g]),
         .sig     (sig_v[g])
      );
   end

   logic                   sel;
   logic                   sign_s;
   logic                   nan_s;
   logic                   inf_s;
   logic signed [XE_W-1:0] exp_s;
   logic [SIG_W-1:0]       sig_s;

   assign sel    = ~op_dbl;
   assign sign_s = sign_v[sel];
   assign nan_s  = nan_v[sel];
   assign inf_s  = inf_v[sel];
   assign exp_s  = exp_v[sel];
   assign sig_s  = sig_v[sel];

   logic [INT_W:0]   mag;
   logic             huge;
   logic             frac_nz;

   f2i_shift_round #(.SIG_W(SIG_W), .INT_W(INT_W), .XE_W(XE_W)) u_round (
      .sign    (sign_s),
      .exp_unb (exp_s),
      .sig     (sig_s),
      .mode    (rnd_mode),
      .mag     (mag),
      .huge    (huge),
      .frac_nz (frac_nz)
   );

   logic [INT_W-1:0] value_d;
   logic             inv_d;
   logic             inx_d;

   f2i_saturate #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_sat (
      .mag        (mag),
      .huge       (huge),
      .frac_nz    (frac_nz),
      .sign       (sign_s),
      .is_nan     (nan_s),
      .dst_wide   (dst_wide),
      .dst_signed (dst_signed),
      .value      (value_d),
      .invalid    (inv_d),
      .inexact    (inx_d)
   );

   logic live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result  <= '0;
         invalid <= 1'b0;
         inexact <= 1'b0;
         live_q  <= 1'b0;
      end else begin
         result  <= value_d;
         invalid <= inv_d;
         inexact <= inx_d;
         live_q  <= 1'b1;
      end
   end

   // R9: the two flags exclude each other
   assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(invalid && inexact));

   // R10: a narrow destination leaves the upper half clear
   assert_narrow_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(!dst_wide)) |-> (result[63:32] == 32'd0));

   // R8: NaN decodes to zero with only invalid
   assert_nan_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(nan_s)) |-> (invalid && !inexact && result == 64'd0));

   // R7: negative input to unsigned destination always yields zero
   assert_unsigned_neg_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(!dst_signed && sign_s && !nan_s)) |-> (result == 64'd0));

   // R6: positive infinity into signed 64-bit clamps to the top value
   assert_signed_inf_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live_q && $past(inf_s && !sign_s && dst_signed && dst_wide))
      |-> (invalid && result == 64'h7FFF_FFFF_FFFF_FFFF));

endmodule

// File: tb/f2i_convert_tb_top.sv
module f2i_convert_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] op_bits;
   logic        op_dbl;
   logic        dst_wide;
   logic        dst_signed;
   logic [2:0]  rnd_mode;
   logic [63:0] result;
   logic        invalid;
   logic        inexact;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   f2i_convert dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_bits    (op_bits),
      .op_dbl     (op_dbl),
      .dst_wide   (dst_wide),
      .dst_signed (dst_signed),
      .rnd_mode   (rnd_mode),
      .result     (result),
      .invalid    (invalid),
      .inexact    (inexact)
   );

   // Fields: req[139:136] dbl[135] wide[134] sgn[133] mode[132:130]
   //         op[129:66] res[65:2] inv[1] inx[0]
   localparam int NV = 40;
   localparam logic [139:0] VEC [NV] = '{
      {4'd1, 3'b111, 3'd0, 64'h4004000000000000, 64'h0000000000000002, 2'b01}, // R1 2.5
      {4'd4, 3'b111, 3'd4, 64'h4004000000000000, 64'h0000000000000003, 2'b01}, // R4 2.5
      {4'd1, 3'b111, 3'd0, 64'h400C000000000000, 64'h0000000000000004, 2'b01}, // R1 3.5
      {4'd2, 3'b111, 3'd1, 64'h3FF4000000000000, 64'h0000000000000002, 2'b01}, // R2 1.25 up
      {4'd2, 3'b111, 3'd2, 64'h3FF4000000000000, 64'h0000000000000001, 2'b01}, // R2 1.25 down
      {4'd3, 3'b111, 3'd3, 64'h4006000000000000, 64'h0000000000000002, 2'b01}, // R3 2.75
      {4'd2, 3'b111, 3'd2, 64'hBFF8000000000000, 64'hFFFFFFFFFFFFFFFE, 2'b01}, // R2 -1.5 down
      {4'd2, 3'b111, 3'd1, 64'hBFF8000000000000, 64'hFFFFFFFFFFFFFFFF, 2'b01}, // R2 -1.5 up
      {4'd3, 3'b111, 3'd3, 64'hC004000000000000, 64'hFFFFFFFFFFFFFFFE, 2'b01}, // R3 -2.5
      {4'd4, 3'b111, 3'd4, 64'hC004000000000000, 64'hFFFFFFFFFFFFFFFD, 2'b01}, // R4 -2.5
      {4'd1, 3'b111, 3'd0, 64'hC004000000000000, 64'hFFFFFFFFFFFFFFFE, 2'b01}, // R1 -2.5
      {4'd1, 3'b111, 3'd0, 64'h3FE0000000000000, 64'h0000000000000000, 2'b01}, // R1 0.5
      {4'd4, 3'b111, 3'd4, 64'h3FE0000000000000, 64'h0000000000000001, 2'b01}, // R4 0.5
      {4'd1, 3'b111, 3'd0, 64'h3FE8000000000000, 64'h0000000000000001, 2'b01}, // R1 0.75
      {4'd2, 3'b111, 3'd1, 64'h0000000000000001, 64'h0000000000000001, 2'b01}, // R2 subnormal up
      {4'd9, 3'b111, 3'd0, 64'h3FF0000000000000, 64'h0000000000000001, 2'b00}, // R9 exact 1.0
      {4'd6, 3'b111, 3'd3, 64'h43E0000000000000, 64'h7FFFFFFFFFFFFFFF, 2'b10}, // R6 2^63
      {4'd6, 3'b111, 3'd3, 64'hC3E0000000000000, 64'h8000000000000000, 2'b00}, // R6 -2^63
      {4'd6, 3'b111, 3'd3, 64'h43DFFFFFFFFFFFFF, 64'h7FFFFFFFFFFFFC00, 2'b00}, // R6 below 2^63
      {4'd7, 3'b110, 3'd3, 64'h43E0000000000000, 64'h8000000000000000, 2'b00}, // R7 2^63 unsigned
      {4'd7, 3'b110, 3'd3, 64'h43F0000000000000, 64'hFFFFFFFFFFFFFFFF, 2'b10}, // R7 2^64
      {4'd7, 3'b110, 3'd3, 64'hBFE0000000000000, 64'h0000000000000000, 2'b01}, // R7 -0.5 to 0
      {4'd7, 3'b110, 3'd2, 64'hBFE0000000000000, 64'h0000000000000000, 2'b10}, // R7 -0.5 to -1
      {4'd7, 3'b110, 3'd0, 64'hBFF8000000000000, 64'h0000000000000000, 2'b10}, // R7 -1.5
      {4'd8, 3'b111, 3'd0, 64'h7FF8000000000000, 64'h0000000000000000, 2'b10}, // R8 NaN
      {4'd8, 3'b111, 3'd3, 64'h7FF0000000000000, 64'h7FFFFFFFFFFFFFFF, 2'b10}, // R8 +inf
      {4'd8, 3'b111, 3'd3, 64'hFFF0000000000000, 64'h8000000000000000, 2'b10}, // R8 -inf
      {4'd6, 3'b101, 3'd3, 64'h41E0000000000000, 64'h000000007FFFFFFF, 2'b10}, // R6 2^31 narrow
      {4'd6, 3'b101, 3'd3, 64'hC1E0000000000000, 64'h0000000080000000, 2'b00}, // R6 -2^31 narrow
      {4'd10,3'b101, 3'd0, 64'hBFF8000000000000, 64'h00000000FFFFFFFE, 2'b01}, // R10 -1.5 narrow
      {4'd7, 3'b100, 3'd3, 64'h41F0000000000000, 64'h00000000FFFFFFFF, 2'b10}, // R7 2^32 narrow
      {4'd9, 3'b111, 3'd0, 64'h8000000000000000, 64'h0000000000000000, 2'b00}, // R9 -0.0
      {4'd5, 3'b011, 3'd0, 64'hDEADBEEF40200000, 64'h0000000000000002, 2'b01}, // R5 single 2.5
      {4'd5, 3'b011, 3'd4, 64'hDEADBEEFBFC00000, 64'hFFFFFFFFFFFFFFFE, 2'b01}, // R5 single -1.5
      {4'd5, 3'b001, 3'd3, 64'h123456784F000000, 64'h000000007FFFFFFF, 2'b10}, // R5 single 2^31 narrow
      {4'd5, 3'b011, 3'd3, 64'hFFFFFFFF4F000000, 64'h0000000080000000, 2'b00}, // R5 single 2^31 wide
      {4'd8, 3'b011, 3'd0, 64'h000000007FC00000, 64'h0000000000000000, 2'b10}, // R8 single NaN
      {4'd7, 3'b000, 3'd1, 64'hAAAAAAAA3F000000, 64'h0000000000000001, 2'b01}, // R7 single 0.5 up
      {4'd3, 3'b111, 3'd7, 64'h4006000000000000, 64'h0000000000000002, 2'b01}, // R3 code 7
      {4'd6, 3'b111, 3'd3, 64'hC3F0000000000000, 64'h8000000000000000, 2'b10}  // R6 -2^64
   };

   task automatic chk(input bit ok, input int req, input string what,
                      input logic [65:0] act, input logic [65:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [139:0] v);
      op_dbl     = v[135];
      dst_wide   = v[134];
      dst_signed = v[133];
      rnd_mode   = v[132:130];
      op_bits    = v[129:66];
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R11 watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [65:0] got;
      rst_n = 1'b0;
      drive({4'd0, 3'b111, 3'd0, 64'h4004000000000000, 64'd0, 2'b00});
      repeat (3) @(negedge clk);
      // R11: outputs held at zero during reset
      got = {result, invalid, inexact};
      chk(got == 66'd0, 11, "reset state", got, 66'd0);
      rst_n = 1'b1;

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         @(negedge clk);
         got = {result, invalid, inexact};
         chk(got == VEC[i][65:0], int'(VEC[i][139:136]),
             $sformatf("vector %0d", i), got, VEC[i][65:0]);
      end

      // R11: one-cycle latency, previous result held until next edge
      @(negedge clk);
      drive({4'd0, 3'b111, 3'd0, 64'h3FF0000000000000, 64'd0, 2'b00});
      @(negedge clk);
      drive({4'd0, 3'b111, 3'd0, 64'h4004000000000000, 64'd0, 2'b00});
      #4;
      got = {result, invalid, inexact};
      chk(got == {64'd1, 2'b00}, 11, "held before edge", got, {64'd1, 2'b00});
      @(negedge clk);
      got = {result, invalid, inexact};
      chk(got == {64'd2, 2'b01}, 11, "updated after edge", got, {64'd2, 2'b01});

      // R11: asynchronous reset mid-run clears at once
      drive({4'd0, 3'b111, 3'd3, 64'h7FF0000000000000, 64'd0, 2'b00});
      @(negedge clk);
      got = {result, invalid, inexact};
      chk(got == {64'h7FFFFFFFFFFFFFFF, 2'b10}, 8, "inf before reset", got,
          {64'h7FFFFFFFFFFFFFFF, 2'b10});
      #3 rst_n = 1'b0;
      #2;
      got = {result, invalid, inexact};
      chk(got == 66'd0, 11, "async reset", got, 66'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5: upper bits of a binary32 operand change nothing
      drive({4'd0, 3'b011, 3'd0, 64'h0000000040200000, 64'd0, 2'b00});
      @(negedge clk);
      got = {result, invalid, inexact};
      chk(got == {64'd2, 2'b01}, 5, "single clean upper", got, {64'd2, 2'b01});
      op_bits[63:32] = 32'h7FF80000;
      @(negedge clk);
      got = {result, invalid, inexact};
      chk(got == {64'd2, 2'b01}, 5, "single dirty upper", got, {64'd2, 2'b01});

      done = 1'b1;
      finish_run();
   end

endmodule